// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This engine sits on the host side of a parallel NOR flash. It waits for an internal program or erase to finish by reading the device's status bits. The command issuer loads the command sequence into the flash and pulses `wr_strobe` once for each write strobe. It then pulses `start` with the operation kind, the polling method, the target address and the data word that was programmed. The engine counts the strobes and holds off until the count makes polling legal. It then issues single read cycles over a simple request/response bus and judges each returned word.

Two judging methods are available. In the data-complement method, bit 7 of each returned word is compared with its final value. For a program, that value is bit 7 of the programmed data. For an erase, it is 1. In the toggle method, bit 6 of each read is compared with bit 6 of the previous read of the same poll. An unchanged bit means the toggling has stopped. Completion runs asynchronously to the reads, so one good-looking word is only a candidate. It must be followed by two more good-looking words before completion is accepted, and any bad word in between restarts the count.

After completion, the other data bits may still be settling. The engine therefore waits a settling interval before it pulses `done`. A cycle timeout ends a poll that never completes by raising `err` together with `done`.

Top module: `fpoll_engine`

## Requirements
- R1: `start` is taken only while the engine is idle. On acceptance the engine latches the operation, method, address and expected data, and `busy` stays high from the next cycle until the `done` cycle. `done` is a single-cycle pulse with `busy` low. A `start` during a poll has no effect on the address read or on the result.
- R2: No read is issued until at least PROG_STROBES (default 4) `wr_strobe` pulses have been counted for a program, or ERASE_STROBES (default 6) for an erase. Strobes are counted while idle as well, and the count is cleared in the `done` cycle.
- R3: At most one read is outstanding. `rd_req` is raised for one cycle and not again until `rsp_valid` has returned, and `rd_addr` always equals the latched address.
- R4: Data method, program: a returned word looks complete when its bit 7 equals bit 7 of the latched expected data.
- R5: Data method, erase: a returned word looks complete when its bit 7 is 1.
- R6: Toggle method: a returned word looks complete when its bit 6 equals bit 6 of the previous word of the same poll. The first word of a poll never looks complete.
- R7: Completion is accepted only after three consecutive words look complete (a candidate plus two confirming reads). Any word that does not look complete restarts the count, and polling continues.
- R8: After accepted completion, `done` rises exactly SETTLE_CYC+1 cycles after the cycle in which the confirming `rsp_valid` was high, with `err` low.
- R9: If TIMEOUT_CYC cycles of waiting for strobes or polling pass without accepted completion, the engine ends the poll at the next point where no read is outstanding. It pulses `done` with `err` high and issues no further reads.
- R10: During and right after reset, `busy`, `done`, `err` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (taken only when idle) |
| op_erase | input | 1 | 1 = erase of any size, 0 = program |
| meth_toggle | input | 1 | 1 = toggle method, 0 = data-complement method |
| poll_addr | input | AW | Address to poll |
| exp_data | input | DW | Data word that was programmed |
| wr_strobe | input | 1 | One pulse per write strobe of the command sequence |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | DW | Returned word |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Poll finished, one-cycle pulse |
| err | output | 1 | Poll ended by timeout, valid with done |

## Verification
Some rules are checked by the assertions on every cycle: the single-cycle done pulse and its separation from busy, the one-read-outstanding protocol, the fixed read address, that no read is issued before the required strobe count, that err appears only with done, and that busy rises only after a start. The bench scenarios are needed for the rest. They show the exact number of reads that each judging method needs, including spurious single and double good-looking words inside a busy stretch. They also show the exact settling delay, the end of a poll by timeout both while waiting for strobes and while polling, and that a start during a poll is ignored.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_ISSUE  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_FIN    = 3'd5
  } fpoll_state_e;

  // Returns the strobe count required before polling is legal.
  function automatic int unsigned strobes_needed(input logic erase,
                                                 input int unsigned prog_n,
                                                 input int unsigned erase_n);
    return erase ? erase_n : prog_n;
  endfunction

endpackage

// File: rtl/fpoll_arm_gate.sv
module fpoll_arm_gate #(
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic clr,
  input  logic erase,
  output logic armed
);
  import fpoll_pkg::*;

  localparam int MAXN = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat;

  assign sat = (cnt_q == CW'(MAXN));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (strobe && !sat) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign armed = (cnt_q >= CW'(strobes_needed(erase, PROG_STROBES, ERASE_STROBES)));

endmodule

// File: rtl/fpoll_status_judge.sv
module fpoll_status_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sample,
  input  logic data_bit,
  input  logic tog_bit,
  input  logic use_toggle,
  input  logic op_erase,
  input  logic exp_bit,
  output logic looks_done
);

  logic prev_q, prev_d;
  logic have_q, have_d;
  logic target;
  logic ok_data, ok_tog;

  assign target  = op_erase ? 1'b1 : exp_bit;
  assign ok_data = (data_bit == target);
  assign ok_tog  = have_q && (tog_bit == prev_q);

  assign looks_done = use_toggle ? ok_tog : ok_data;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (restart) begin
      have_d = 1'b0;
    end else if (sample) begin
      prev_d = tog_bit;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

endmodule

// File: rtl/fpoll_tick_counter.sv
module fpoll_tick_counter #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last,
  output logic full
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign full = (cnt_q == CW'(LIMIT));
  assign last = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !full) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fpoll_engine.sv
module fpoll_engine #(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int DBIT          = 7,
  parameter int TBIT          = 6,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int CONFIRM_READS = 2,
  parameter int TIMEOUT_CYC   = 400,
  parameter int SETTLE_CYC    = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          meth_toggle,
  input  logic [AW-1:0] poll_addr,
  input  logic [DW-1:0] exp_data,
  input  logic          wr_strobe,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  import fpoll_pkg::*;

  localparam int CFW = $clog2(CONFIRM_READS + 1);

  fpoll_state_e  state_q, state_d;
  logic [CFW-1:0] conf_q, conf_d;
  logic          err_q, err_d;
  logic [AW-1:0] addr_q;
  logic          erase_q, toggle_q, exp_q;

  logic accept;
  logic armed;
  logic sample;
  logic looks_done;
  logic tmo;
  logic tmo_last_unused;
  logic settle_last;
  logic settle_full_unused;
  logic poll_en;
  logic rd_go;
  logic unused_bits;

  assign accept  = (state_q == ST_IDLE) && start;
  assign sample  = (state_q == ST_WAIT) && rsp_valid;
  assign poll_en = (state_q == ST_ARM) || (state_q == ST_ISSUE) || (state_q == ST_WAIT);

  // Only the status bits of the words are judged.
  assign unused_bits = &{1'b0, rsp_data, exp_data};

  fpoll_arm_gate #(
    .PROG_STROBES (PROG_STROBES),
    .ERASE_STROBES(ERASE_STROBES)
  ) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(wr_strobe),
    .clr   (state_q == ST_FIN),
    .erase (erase_q),
    .armed (armed)
  );

  fpoll_status_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .sample    (sample),
    .data_bit  (rsp_data[DBIT]),
    .tog_bit   (rsp_data[TBIT]),
    .use_toggle(toggle_q),
    .op_erase  (erase_q),
    .exp_bit   (exp_q),
    .looks_done(looks_done)
  );

  fpoll_tick_counter #(.LIMIT(TIMEOUT_CYC)) u_timeout (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (poll_en),
    .last (tmo_last_unused),
    .full (tmo)
  );

  fpoll_tick_counter #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_q != ST_SETTLE),
    .en   (state_q == ST_SETTLE),
    .last (settle_last),
    .full (settle_full_unused)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    conf_d  = conf_q;
    err_d   = err_q;
    rd_go   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ARM;
          conf_d  = '0;
          err_d   = 1'b0;
        end
      end
      ST_ARM: begin
        if (tmo) begin
          state_d = ST_FIN;
          err_d   = 1'b1;
        end else if (armed) begin
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (tmo) begin
          state_d = ST_FIN;
          err_d   = 1'b1;
        end else begin
          rd_go   = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          state_d = ST_ISSUE;
          if (looks_done) begin
            if (conf_q == CFW'(CONFIRM_READS)) begin
              state_d = ST_SETTLE;
            end else begin
              conf_d = conf_q + CFW'(1);
            end
          end else begin
            conf_d = '0;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_last) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      conf_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      conf_q  <= conf_d;
      err_q   <= err_d;
    end
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      exp_q    <= 1'b0;
    end else if (accept) begin
      addr_q   <= poll_addr;
      erase_q  <= op_erase;
      toggle_q <= meth_toggle;
      exp_q    <= exp_data[DBIT];
    end
  end

  assign rd_req  = rd_go;
  assign rd_addr = addr_q;
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done    = (state_q == ST_FIN);
  assign err     = (state_q == ST_FIN) && err_q;

endmodule

// File: rtl/fpoll_engine_chk.sv
module fpoll_engine_chk #(
  parameter int AW            = 20,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          op_erase,
  input logic [AW-1:0] poll_addr,
  input logic          wr_strobe,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rsp_valid,
  input logic          busy,
  input logic          done,
  input logic          err
);

  localparam int SW = $clog2(ERASE_STROBES + PROG_STROBES + 1);

  logic [SW-1:0] stb_q;
  logic          need_erase_q;
  logic [AW-1:0] cap_addr_q;
  logic          outst_q;
  logic          took;

  assign took = start && !busy && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q        <= '0;
      need_erase_q <= 1'b0;
      cap_addr_q   <= '0;
      outst_q      <= 1'b0;
    end else begin
      if (done) begin
        stb_q <= '0;
      end else if (wr_strobe && (stb_q != {SW{1'b1}})) begin
        stb_q <= stb_q + SW'(1);
      end
      if (took) begin
        need_erase_q <= op_erase;
        cap_addr_q   <= poll_addr;
      end
      if (rd_req) begin
        outst_q <= 1'b1;
      end else if (rsp_valid) begin
        outst_q <= 1'b0;
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_req_after_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (stb_q >= SW'(need_erase_q ? ERASE_STROBES : PROG_STROBES)));

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outst_q);

  p_req_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr == cap_addr_q));

  p_req_in_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind fpoll_engine fpoll_engine_chk #(
  .AW           (AW),
  .PROG_STROBES (PROG_STROBES),
  .ERASE_STROBES(ERASE_STROBES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op_erase (op_erase),
  .poll_addr(poll_addr),
  .wr_strobe(wr_strobe),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rsp_valid(rsp_valid),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/sim_fpoll_engine.sv
module sim_fpoll_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 20;
  localparam int DW         = 16;
  localparam int SETTLE     = 50;
  localparam int TIMEOUT    = 400;
  localparam int LAT        = 2;

  typedef struct packed {
    logic       er;
    logic       tg;
    logic       e7;
    logic [7:0] nb;
    logic [7:0] gp;
    logic [1:0] gl;
  } vec_t;

  // er, tg, e7, busy reads, glitch position, glitch length
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b1, 8'd5,  8'd255, 2'd0},
    '{1'b0, 1'b0, 1'b0, 8'd0,  8'd255, 2'd0},
    '{1'b1, 1'b0, 1'b0, 8'd6,  8'd255, 2'd0},
    '{1'b0, 1'b1, 1'b1, 8'd7,  8'd255, 2'd0},
    '{1'b1, 1'b1, 1'b0, 8'd0,  8'd255, 2'd0},
    '{1'b0, 1'b0, 1'b1, 8'd8,  8'd2,   2'd1},
    '{1'b1, 1'b0, 1'b1, 8'd9,  8'd3,   2'd2},
    '{1'b0, 1'b1, 1'b0, 8'd10, 8'd2,   2'd2},
    '{1'b1, 1'b1, 1'b1, 8'd8,  8'd3,   2'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          op_erase;
  logic          meth_toggle;
  logic [AW-1:0] poll_addr;
  logic [DW-1:0] exp_data;
  logic          wr_strobe;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          busy;
  logic          done;
  logic          err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // flash model state
  bit            m_erase, m_exp7;
  int            m_nbusy, m_gpos, m_glen;
  logic [AW-1:0] m_addr;
  logic          m_prev_b6;
  int            rd_idx, reads, addr_bad, first_req, pend;
  int            last_rsp_cyc, done_cyc;
  bit            done_seen, err_seen;
  logic [DW-1:0] pend_data;

  fpoll_engine #(
    .AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT), .SETTLE_CYC(SETTLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .meth_toggle(meth_toggle), .poll_addr(poll_addr), .exp_data(exp_data),
    .wr_strobe(wr_strobe), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] model_word(input int i);
    logic [DW-1:0] d;
    logic          tgt, b6;
    bit            gl;
    tgt = m_erase ? 1'b1 : m_exp7;
    gl  = (m_glen > 0) && (i >= m_gpos) && (i < m_gpos + m_glen);
    d   = DW'(i * 37 + 16'h1234);
    if (i >= m_nbusy || gl) begin
      d[7] = tgt;
      b6   = m_prev_b6;
    end else begin
      d[7] = ~tgt;
      b6   = i[0];
    end
    d[6]      = b6;
    m_prev_b6 = b6;
    return d;
  endfunction

  // bus responder and monitor
  initial begin
    rsp_valid = 1'b0;
    rsp_data  = '0;
    pend      = -1;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend == 0) begin
        rsp_valid    = 1'b1;
        rsp_data     = pend_data;
        last_rsp_cyc = cyc;
        pend         = -1;
      end else if (pend > 0) begin
        pend = pend - 1;
      end
      if (rd_req) begin
        reads = reads + 1;
        if (rd_addr !== m_addr) addr_bad = addr_bad + 1;
        if (first_req < 0) first_req = cyc;
        pend_data = model_word(rd_idx);
        rd_idx    = rd_idx + 1;
        pend      = LAT - 1;
      end
      if (done) begin
        done_seen = 1'b1;
        done_cyc  = cyc;
        err_seen  = err;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk); wr_strobe = 1'b1;
    @(negedge clk); wr_strobe = 1'b0;
  endtask

  task automatic begin_poll(input bit er, input bit tg, input bit e7, input int nb,
                            input int gp, input int gl, input logic [AW-1:0] a,
                            input int nstb);
    m_erase = er; m_exp7 = e7; m_nbusy = nb; m_gpos = gp; m_glen = gl;
    m_addr = a; m_prev_b6 = 1'b0; rd_idx = 0; reads = 0; addr_bad = 0;
    done_seen = 1'b0; err_seen = 1'b0; first_req = -1;
    repeat (nstb) pulse_strobe();
    @(negedge clk);
    start = 1'b1; op_erase = er; meth_toggle = tg; poll_addr = a;
    exp_data = {8'h3C, e7, 7'h25};
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; meth_toggle = 1'b0;
    poll_addr = '0; exp_data = '0; wr_strobe = 1'b0;
    reads = 0; addr_bad = 0; first_req = -1; done_seen = 0; err_seen = 0;
    m_addr = '0; rd_idx = 0; m_nbusy = 0; m_gpos = 255; m_glen = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "busy in reset", int'(busy), 0);
    chk("R10", "done/err/req in reset", int'(done | err | rd_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "outputs after reset", int'({busy, done, err, rd_req}), 0);

    // table walk: R4 R5 R6 R7 R8 R3
    for (int v = 0; v < 9; v++) begin
      vec_t x;
      int   nb, expr;
      string tag;
      x    = VECS[v];
      nb   = int'(x.nb);
      expr = x.tg ? ((nb < 1 ? 1 : nb) + 3) : nb + 3;
      tag  = x.tg ? "R6" : (x.er ? "R5" : "R4");
      if (x.gl != 0) tag = {tag, "/R7"};
      begin_poll(x.er, x.tg, x.e7, nb, int'(x.gp), int'(x.gl),
                 AW'(20'h05555 + v * 16'h0101), x.er ? 6 : 4);
      wait_done();
      chk("R8", "done seen", int'(done_seen), 1);
      chk("R8", "err on completion", int'(err_seen), 0);
      chk(tag, "read count", reads, expr);
      chk("R8", "settle gap", done_cyc - last_rsp_cyc, SETTLE + 1);
      chk("R3", "address mismatches", addr_bad, 0);
    end

    // R2: program gated until fourth strobe
    begin_poll(1'b0, 1'b0, 1'b1, 0, 255, 0, 20'h02AAA, 2);
    repeat (30) @(negedge clk);
    chk("R2", "reads before 4th strobe", reads, 0);
    repeat (2) pulse_strobe();
    wait_done();
    chk("R2", "reads after 4th strobe", reads, 3);
    chk("R2", "err after gating", int'(err_seen), 0);

    // R2: erase gated until sixth strobe
    begin_poll(1'b1, 1'b1, 1'b0, 2, 255, 0, 20'h01234, 4);
    repeat (30) @(negedge clk);
    chk("R2", "erase reads before 6th strobe", reads, 0);
    repeat (2) pulse_strobe();
    wait_done();
    chk("R2", "erase reads after 6th strobe", reads, 5);

    // R1: start during a poll is ignored
    begin_poll(1'b0, 1'b0, 1'b0, 10, 255, 0, 20'h0F0F0, 4);
    repeat (8) @(negedge clk);
    start = 1'b1; op_erase = 1'b1; poll_addr = 20'h0ABCD;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "busy during poll", int'(busy), 1);
    wait_done();
    chk("R1", "address kept", addr_bad, 0);
    chk("R1", "read count kept", reads, 13);

    // R9: timeout while polling, no reads afterwards
    begin_poll(1'b0, 1'b1, 1'b1, 1000, 255, 0, 20'h03333, 4);
    wait_done();
    chk("R9", "done on timeout", int'(done_seen), 1);
    chk("R9", "err on timeout", int'(err_seen), 1);
    begin
      int r0;
      r0 = reads;
      repeat (20) @(negedge clk);
      chk("R9", "reads after timeout", reads, r0);
    end

    // R9/R2: timeout while waiting for strobes (count cleared at done)
    begin_poll(1'b1, 1'b0, 1'b0, 0, 255, 0, 20'h04444, 0);
    wait_done();
    chk("R9", "err on strobe wait timeout", int'(err_seen), 1);
    chk("R2", "no read without strobes", reads, 0);
    chk("R1", "idle after done", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule